// File: doc/BRIEF.md
# Per-Source Interrupt Trigger Detector

This block conditions a bank of interrupt source lines before they reach the interrupt controller's registers. Three configuration bits per source pick its trigger. A sensitivity bit chooses level or edge. For level sources a polarity bit chooses active high or active low. For edge sources a dual-edge bit selects detection of any change, and otherwise the polarity bit chooses between a rising and a falling edge. The output is one raw pending bit per source.

The block samples all source lines on every clock and keeps the last sampled level of each line, so an edge is found by comparing the new sample with the old one. A level source's raw bit follows its line, one clock behind. An edge source's raw bit latches when an edge is found and stays set until software writes a one to that source's bit of the clear mask. The clear mask has no effect on level sources. If a new edge and a clear reach the same source in the same cycle, the edge wins. Synchronising the source lines into this clock domain is left to the logic in front of the block.

Top module: `irq_trig_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `raw_pend` is all zeros.
- R2: When `cfg_level` is 1, the source is level-sensitive. When `cfg_pol` is 1, `raw_pend` at the next clock equals the sampled line. When `cfg_pol` is 0, it equals the inverse of the sampled line.
- R3: When `cfg_level` is 0 and `cfg_both` is 1, any difference between the new sample and the stored level sets the raw bit.
- R4: When `cfg_level` is 0 and `cfg_both` is 0, `cfg_pol` set to 1 detects a 0-to-1 transition only, and `cfg_pol` set to 0 detects a 1-to-0 transition only.
- R5: An edge-sensitive raw bit, once set, stays set in later cycles as long as its `edge_clr` bit is 0, whatever the line does.
- R6: A 1 in `edge_clr` clears that source's raw bit at the next clock only when the source is edge-sensitive. Level-sensitive raw bits ignore `edge_clr`.
- R7: If an edge is detected on a source in the same cycle that its `edge_clr` bit is 1, the raw bit is set at the next clock.
- R8: The stored level of each source is updated from its line on every clock and resets to 0. A line that is already high at the first sample after reset therefore counts as a rising edge.
- R9: Each source is configured and detected independently. Stimulus on one source never changes another source's raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | N_SRC | Synchronised source line levels |
| cfg_level | input | N_SRC | 1 = level-sensitive, 0 = edge-sensitive |
| cfg_both | input | N_SRC | 1 = detect both edges (edge sources only) |
| cfg_pol | input | N_SRC | Level: 1 = active high. Single edge: 1 = rising |
| edge_clr | input | N_SRC | One-cycle clear mask for edge pending bits |
| raw_pend | output | N_SRC | Raw pending vector |

## Verification
A new edge and a clear request can reach the same source in one cycle. The bench provokes this by raising a rising-edge source's line in the same step that its `edge_clr` bit is set. It judges the case correct when the pending bit reads 1 after that clock, and then reads 0 after a following clear-only step with the line held steady. The bench also applies a clear to a level source whose raw bit is 1 and expects that bit to stay 1.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    localparam int unsigned IRQ_SRC_DEFAULT = 51;

    typedef enum logic [2:0] {
        TRIG_LVL_LOW   = 3'd0,
        TRIG_LVL_HIGH  = 3'd1,
        TRIG_EDGE_FALL = 3'd2,
        TRIG_EDGE_RISE = 3'd3,
        TRIG_EDGE_BOTH = 3'd4
    } trig_mode_e;

    function automatic trig_mode_e trig_decode(input logic is_level,
                                               input logic any_edge,
                                               input logic pol);
        trig_mode_e m;
        if (is_level)      m = pol ? TRIG_LVL_HIGH : TRIG_LVL_LOW;
        else if (any_edge) m = TRIG_EDGE_BOTH;
        else               m = pol ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
        return m;
    endfunction

endpackage

// File: rtl/irq_trig_mode_dec.sv
module irq_trig_mode_dec
    import irq_trig_pkg::*;
#(
    parameter int unsigned N_SRC = IRQ_SRC_DEFAULT
) (
    input  logic [N_SRC-1:0] cfg_level,
    input  logic [N_SRC-1:0] cfg_both,
    input  logic [N_SRC-1:0] cfg_pol,
    output trig_mode_e       mode [N_SRC]
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_dec
        assign mode[i] = trig_decode(cfg_level[i], cfg_both[i], cfg_pol[i]);
    end
endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
    import irq_trig_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       lvl_now,
    input  logic       lvl_prev,
    input  logic       pend_q,
    input  logic       clr,
    output logic       pend_d
);
    logic rise, fall, hit, keep;

    always_comb begin
        rise = lvl_now & ~lvl_prev;
        fall = ~lvl_now & lvl_prev;
        keep = pend_q & ~clr;
        unique case (mode)
            TRIG_LVL_HIGH:  begin hit = 1'b0; pend_d = lvl_now;         end
            TRIG_LVL_LOW:   begin hit = 1'b0; pend_d = ~lvl_now;        end
            TRIG_EDGE_RISE: begin hit = rise; pend_d = hit | keep;      end
            TRIG_EDGE_FALL: begin hit = fall; pend_d = hit | keep;      end
            TRIG_EDGE_BOTH: begin hit = rise | fall; pend_d = hit | keep; end
            default:        begin hit = 1'b0; pend_d = 1'b0;            end
        endcase
    end
endmodule

// File: rtl/irq_trig_unit.sv
module irq_trig_unit
    import irq_trig_pkg::*;
#(
    parameter int unsigned N_SRC = IRQ_SRC_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic [N_SRC-1:0] cfg_level,
    input  logic [N_SRC-1:0] cfg_both,
    input  logic [N_SRC-1:0] cfg_pol,
    input  logic [N_SRC-1:0] edge_clr,
    output logic [N_SRC-1:0] raw_pend
);
    localparam logic [N_SRC-1:0] ALL_ZERO = '0;

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] pend;
    } trig_state_t;

    trig_state_t      st_d, st_q;
    trig_mode_e       mode [N_SRC];
    logic [N_SRC-1:0] pend_next;
    logic [N_SRC-1:0] prev_lvl;

    irq_trig_mode_dec #(.N_SRC(N_SRC)) u_dec (
        .cfg_level (cfg_level),
        .cfg_both  (cfg_both),
        .cfg_pol   (cfg_pol),
        .mode      (mode)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        irq_trig_cell u_cell (
            .mode     (mode[i]),
            .lvl_now  (src_lvl[i]),
            .lvl_prev (st_q.prev[i]),
            .pend_q   (st_q.pend[i]),
            .clr      (edge_clr[i]),
            .pend_d   (pend_next[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_lvl;
        st_d.pend = pend_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= ALL_ZERO;
            st_q.pend <= ALL_ZERO;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_pend = st_q.pend;
    assign prev_lvl = st_q.prev;
endmodule

// File: rtl/irq_trig_chk.sv
module irq_trig_chk #(
    parameter int unsigned N_SRC = 51
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_lvl,
    input logic [N_SRC-1:0] cfg_level,
    input logic [N_SRC-1:0] cfg_both,
    input logic [N_SRC-1:0] cfg_pol,
    input logic [N_SRC-1:0] edge_clr,
    input logic [N_SRC-1:0] prev_lvl,
    input logic [N_SRC-1:0] raw_pend
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> raw_pend == '0);

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (raw_pend & $past(cfg_level)) ==
                 ((~($past(src_lvl) ^ $past(cfg_pol))) & $past(cfg_level)));

    // R3
    dual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(~cfg_level & cfg_both & (src_lvl ^ prev_lvl)) & ~raw_pend) == '0);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(raw_pend & ~cfg_level & ~edge_clr) & ~raw_pend) == '0);

    // R6
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(~cfg_level & edge_clr & ~(src_lvl ^ prev_lvl)) & raw_pend) == '0);

    // R8
    prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_lvl == $past(src_lvl));
endmodule

bind irq_trig_unit irq_trig_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .cfg_level (cfg_level),
    .cfg_both  (cfg_both),
    .cfg_pol   (cfg_pol),
    .edge_clr  (edge_clr),
    .prev_lvl  (prev_lvl),
    .raw_pend  (raw_pend)
);

// File: tb/tb_irq_trig_unit.sv
module tb_irq_trig_unit;
    localparam int N = 51;
    localparam int NSTEP = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_lvl = '0, cfg_level = '0, cfg_both = '0, cfg_pol = '0, edge_clr = '0;
    logic [N-1:0] raw_pend;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_trig_unit #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .cfg_level(cfg_level),
        .cfg_both(cfg_both), .cfg_pol(cfg_pol), .edge_clr(edge_clr), .raw_pend(raw_pend)
    );

    // {src, level, both, pol, clr, expected}
    localparam logic [5:0] VEC [NSTEP] = '{
        6'b1_1_0_1_0_1, // R2 active high, line 1
        6'b0_1_0_1_0_0, // R2 active high, line 0
        6'b0_1_0_0_0_1, // R2 active low, line 0
        6'b0_1_0_0_1_1, // R6 clear ignored on level source
        6'b1_1_0_0_0_0, // R2 active low, line 1
        6'b0_0_0_1_0_0, // R4 falling edge, rising mode: no hit
        6'b1_0_0_1_0_1, // R4 rising edge detected
        6'b1_0_0_1_0_1, // R5 held
        6'b0_0_0_1_0_1, // R5 sticky through falling line
        6'b0_0_0_1_1_0, // R6 clear
        6'b1_0_0_1_1_1, // R7 edge beats clear
        6'b1_0_0_1_1_0, // R6 clear, no edge
        6'b0_0_0_0_0_1, // R4 falling mode, falling edge
        6'b0_0_0_0_1_0, // R6 clear
        6'b1_0_0_0_0_0, // R4 falling mode ignores rising edge
        6'b0_0_1_0_0_1, // R3 dual, falling
        6'b0_0_1_0_1_0, // R6 clear
        6'b1_0_1_0_0_1, // R3 dual, rising
        6'b1_0_1_0_1_0, // R6 clear
        6'b1_0_1_0_0_0  // R3 no change, no hit
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: raw_pend actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] sel, exp, even;
        sel = '0;
        sel[0] = 1'b1;
        sel[N-1] = 1'b1;
        // The other sources stay level, active high, line low.
        cfg_level = ~sel;
        cfg_pol = ~sel;
        src_lvl = '1;
        repeat (3) tick();
        check("R1 reset", raw_pend, '0);
        rst_n = 1'b1;
        src_lvl = '0;
        tick();
        check("R1 first cycle", raw_pend, '0);

        for (int k = 0; k < NSTEP; k++) begin
            src_lvl   = VEC[k][5] ? sel : '0;
            cfg_level = VEC[k][4] ? '1 : ~sel;
            cfg_both  = VEC[k][3] ? sel : '0;
            cfg_pol   = VEC[k][2] ? '1 : ~sel;
            edge_clr  = VEC[k][1] ? '1 : '0;
            tick();
            exp = VEC[k][0] ? sel : '0;
            check($sformatf("R2-R7 step %0d", k), raw_pend, exp);
        end

        // R8: a line high at the first sample after reset is a rising edge.
        edge_clr = '0;
        cfg_level = '0;
        cfg_both = '0;
        cfg_pol = '1;
        src_lvl = '1;
        rst_n = 1'b0;
        tick();
        tick();
        check("R1 reset mid-run", raw_pend, '0);
        rst_n = 1'b1;
        tick();
        check("R8 stored level resets to 0", raw_pend, '1);
        edge_clr = '1;
        tick();
        edge_clr = '0;
        check("R8 held high, no new edge", raw_pend, '0);

        // R9: independence, even sources rise, level odd sources active low.
        even = '0;
        for (int i = 0; i < N; i += 2) even[i] = 1'b1;
        src_lvl = '0;
        edge_clr = '1;
        tick();
        edge_clr = '0;
        cfg_level = ~even;
        cfg_pol = even;
        src_lvl = even;
        tick();
        check("R9 mixed sources", raw_pend, '1);
        src_lvl = '1;
        edge_clr = even & ~(even - 1'b1);
        tick();
        edge_clr = '0;
        exp = even & ~(even & ~(even - 1'b1));
        check("R9 one edge source cleared, level sources inactive", raw_pend, exp);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule